// File: doc/BRIEF.md
# Peripheral Idle Handshake and System Configuration Controller

This block lets a peripheral take part in a chip-level idle protocol. The power manager raises an idle request. The block decides when to acknowledge it, according to a programmable idle policy and the busy indication from the peripheral. While the acknowledge is held, the block treats itself as idle and refuses register traffic. The same configuration word also controls two other things: whether a debug suspend input freezes the peripheral's counters, and a self-clearing software reset that drives a fixed-length reset pulse into the peripheral.

Software reaches the configuration word over a simple single-beat register bus. Each request is answered exactly one cycle later with a valid strobe, an error flag and read data. Only one byte offset is decoded. A request to any other offset is refused, and so is any request made while the block is idle. The idle policies are forced (acknowledge at once), never (no acknowledge at all) and activity-gated (acknowledge once the peripheral is no longer busy). The unused policy code behaves as activity-gated.

Top module: `idle_sysctl`

## Requirements
- R1: After reset: the configuration word reads 0x00000008 (idle policy 2 in bits 3:2, bit 1 = 0, bit 0 = 0); `idle_ack_o`, `idle_state_o`, `freeze_o` and `mod_rst_o` are 0.
- R2: With idle policy 0 (forced) in bits 3:2, `idle_ack_o` is 1 in the cycle after `idle_req_i` is sampled high, whatever `busy_i` is.
- R3: With idle policy 1 (never), `idle_ack_o` stays 0 for as long as the policy is selected, whatever `idle_req_i` does.
- R4: With idle policy 2 (activity-gated), `idle_ack_o` rises in the cycle after a clock edge that samples `idle_req_i` high and `busy_i` low. Once risen, it stays high while `idle_req_i` stays high, even if `busy_i` rises again.
- R5: Idle policy code 3 behaves exactly as policy 2.
- R6: `idle_ack_o` falls in the cycle after `idle_req_i` is sampled low. `idle_state_o` always equals `idle_ack_o`.
- R7: A bus request accepted while `idle_state_o` is 1 returns `bus_err_o` = 1 with `bus_rdata_o` = 0. A write made that way leaves the configuration word unchanged.
- R8: Bits 3:2 (idle policy) and bit 1 (debug-suspend immunity) are read/write. Bits 31:4 read as 0 and ignore written values.
- R9: `freeze_o` equals `dbg_suspend_i AND NOT bit 1`, delayed by one clock.
- R10: A write of 1 to bit 0, made while no software reset is running, drives `mod_rst_o` high for exactly SRST_CYCLES (default 4) cycles, starting the cycle after the write. Bit 0 reads 1 during the pulse and 0 afterwards.
- R11: A request to any byte offset other than CFG_OFFSET (default 4) returns `bus_err_o` = 1 and `bus_rdata_o` = 0, and has no effect.
- R12: Every request sampled on `bus_req_i` produces `bus_rsp_o` = 1 in the next cycle. With no request, `bus_rsp_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req_i | input | 1 | Register request strobe, one cycle per request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the request |
| bus_wdata_i | input | 32 | Write data |
| bus_rsp_o | output | 1 | Response strobe, one cycle after the request |
| bus_err_o | output | 1 | Request refused (idle or undecoded offset) |
| bus_rdata_o | output | 32 | Read data, 0 on error or write |
| idle_req_i | input | 1 | System idle request |
| busy_i | input | 1 | Peripheral reports internal activity |
| dbg_suspend_i | input | 1 | Debug suspend request |
| idle_ack_o | output | 1 | Idle acknowledge to the power manager |
| idle_state_o | output | 1 | Block is idle; register access is blocked |
| freeze_o | output | 1 | Freeze the peripheral's counters |
| mod_rst_o | output | 1 | Reset pulse into the peripheral |

## Verification
The bench goes after the activity-gated hold. A design that re-evaluates `busy_i` while acknowledged would drop the acknowledge in the middle of an idle period. It also drives policy code 3: a design that decodes 3 as never or as forced would withhold the acknowledge, or give it too early, while busy. Writes made while idle and writes to the wrong offset are checked by reading the word back afterwards, so a leaky write path changes the readback. The soft reset is timed cycle by cycle and read back both during and after the pulse, so an off-by-one pulse length or a bit that never clears shows up. A long random phase checks every output against the reference model on every clock.

// File: rtl/idle_sysctl_pkg.sv
// Package: shared types and field positions for the idle/sysconfig controller.
// Assumes a 32-bit configuration word; the field positions are the contract with software.
package idle_sysctl_pkg;

    localparam int REG_W     = 32;
    localparam int MODE_LSB  = 2;
    localparam int IMMUNE_BIT = 1;
    localparam int SRST_BIT  = 0;

    // Idle policy encodings held in bits 3:2
    typedef enum logic [1:0] {
        POL_FORCE = 2'd0,
        POL_NEVER = 2'd1,
        POL_GATED = 2'd2,
        POL_SPARE = 2'd3
    } idle_pol_e;

    localparam idle_pol_e POL_RESET = POL_GATED;

endpackage

// File: rtl/idle_sysctl_idle.sv
// Module: idle acknowledge generator.
// Applies the selected idle policy to the system idle request and the peripheral's
// busy flag. Assumes the policy input only changes while the acknowledge is low.
module idle_sysctl_idle
    import idle_sysctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle_req_i,
    input  logic      busy_i,
    input  idle_pol_e pol_i,
    output logic      ack_o
);

    logic ack_q;
    logic ack_d;

    // Next acknowledge value from the policy, request and activity
    always_comb begin
        unique case (pol_i)
            POL_FORCE: ack_d = idle_req_i;
            POL_NEVER: ack_d = 1'b0;
            default:   ack_d = idle_req_i && (ack_q || !busy_i);
        endcase
    end

    // Acknowledge register
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ack_d;
    end

    assign ack_o = ack_q;

    // R2
    force_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_i == POL_FORCE && idle_req_i) |=> ack_q);

    // R3
    never_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_i == POL_NEVER && !ack_q) |=> !ack_q);

    // R4
    gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && idle_req_i && pol_i != POL_NEVER) |=> ack_q);

    // R6
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_req_i |=> !ack_q);

endmodule

// File: rtl/idle_sysctl_srst.sv
// Module: software-reset pulse stretcher.
// A start strobe loads a down-counter; the reset output is high while it is nonzero.
// Assumes start is only raised while the counter is idle.
module idle_sysctl_srst #(
    parameter int CYCLES = 4,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (start_i && cnt_q == '0) cnt_q <= CNT_W'(CYCLES);
        else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    // R10
    srst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R10
    srst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

endmodule

// File: rtl/idle_sysctl_regs.sv
// Module: configuration word and register bus slave.
// Decodes a single offset, answers each request one cycle later and refuses
// access while idle. Assumes one-cycle request strobes.
module idle_sysctl_regs
    import idle_sysctl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CFG_OFFSET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic              rsp_o,
    output logic              err_o,
    output logic [REG_W-1:0]  rdata_o,
    input  logic              idle_i,
    input  logic              srst_busy_i,
    output idle_pol_e         pol_o,
    output logic              immune_o,
    output logic              srst_start_o
);

    logic             hit;
    logic             ok;
    idle_pol_e        pol_q;
    logic             immune_q;
    logic [REG_W-1:0] word;

    // Accept only the decoded offset and only while not idle
    assign hit = (addr_i == ADDR_W'(CFG_OFFSET));
    assign ok  = req_i && hit && !idle_i;

    // Readback word: upper bits are always zero
    always_comb begin
        word = '0;
        word[MODE_LSB +: 2] = pol_q;
        word[IMMUNE_BIT]    = immune_q;
        word[SRST_BIT]      = srst_busy_i;
    end

    // Configuration fields, written by accepted writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q    <= POL_RESET;
            immune_q <= 1'b0;
        end else if (ok && we_i) begin
            pol_q    <= idle_pol_e'(wdata_i[MODE_LSB +: 2]);
            immune_q <= wdata_i[IMMUNE_BIT];
        end
    end

    // Response one cycle after each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_o   <= 1'b0;
            err_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            rsp_o   <= req_i;
            err_o   <= req_i && !ok;
            rdata_o <= (ok && !we_i) ? word : '0;
        end
    end

    assign srst_start_o = ok && we_i && wdata_i[SRST_BIT] && !srst_busy_i;
    assign pol_o        = pol_q;
    assign immune_o     = immune_q;

    // R7
    idle_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && idle_i) |=> (err_o && rdata_o == '0));

    // R7
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && idle_i) |=> ($stable(pol_q) && $stable(immune_q)));

    // R11
    miss_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !hit) |=> (err_o && $stable(pol_q)));

    // R12
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> rsp_o);

    // R12
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !rsp_o);

endmodule

// File: rtl/idle_sysctl.sv
// Module: top of the idle handshake and system configuration controller.
// Ties the register slave, idle acknowledge generator and soft-reset stretcher
// together and registers the debug freeze. Assumes all inputs are synchronous to clk.
module idle_sysctl
    import idle_sysctl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int CFG_OFFSET  = 4,
    parameter int SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic              bus_rsp_o,
    output logic              bus_err_o,
    output logic [31:0]       bus_rdata_o,
    input  logic              idle_req_i,
    input  logic              busy_i,
    input  logic              dbg_suspend_i,
    output logic              idle_ack_o,
    output logic              idle_state_o,
    output logic              freeze_o,
    output logic              mod_rst_o
);

    idle_pol_e pol;
    logic      immune;
    logic      srst_start;
    logic      srst_busy;
    logic      ack;
    logic      freeze_q;

    idle_sysctl_regs #(
        .ADDR_W     (ADDR_W),
        .CFG_OFFSET (CFG_OFFSET)
    ) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (bus_req_i),
        .we_i         (bus_we_i),
        .addr_i       (bus_addr_i),
        .wdata_i      (bus_wdata_i),
        .rsp_o        (bus_rsp_o),
        .err_o        (bus_err_o),
        .rdata_o      (bus_rdata_o),
        .idle_i       (ack),
        .srst_busy_i  (srst_busy),
        .pol_o        (pol),
        .immune_o     (immune),
        .srst_start_o (srst_start)
    );

    idle_sysctl_idle idle_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_req_i (idle_req_i),
        .busy_i     (busy_i),
        .pol_i      (pol),
        .ack_o      (ack)
    );

    idle_sysctl_srst #(
        .CYCLES (SRST_CYCLES)
    ) srst_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (srst_start),
        .busy_o  (srst_busy)
    );

    // Debug freeze, gated by the immunity bit
    always_ff @(posedge clk) begin
        if (!rst_n) freeze_q <= 1'b0;
        else        freeze_q <= dbg_suspend_i && !immune;
    end

    assign idle_ack_o   = ack;
    assign idle_state_o = ack;
    assign freeze_o     = freeze_q;
    assign mod_rst_o    = srst_busy;

    // R9
    freeze_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_suspend_i && !immune) |=> freeze_o);

    // R9
    freeze_immune_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (immune || !dbg_suspend_i) |=> !freeze_o);

endmodule

// File: tb/idle_sysctl_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module idle_sysctl_tb_top;

    localparam int ADDR_W = 8;
    localparam int OFF    = 4;
    localparam int NRST   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req_i = 1'b0;
    logic        bus_we_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic        bus_rsp_o, bus_err_o;
    logic [31:0] bus_rdata_o;
    logic        idle_req_i = 1'b0, busy_i = 1'b0, dbg_suspend_i = 1'b0;
    logic        idle_ack_o, idle_state_o, freeze_o, mod_rst_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit live   = 0;

    // Reference model state
    int m_pol, m_imm, m_cnt, m_ack, m_frz, m_rsp, m_err;
    logic [31:0] m_rdata;

    always #4 clk = ~clk;

    idle_sysctl #(.ADDR_W(ADDR_W), .CFG_OFFSET(OFF), .SRST_CYCLES(NRST)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rsp_o(bus_rsp_o), .bus_err_o(bus_err_o),
        .bus_rdata_o(bus_rdata_o), .idle_req_i(idle_req_i), .busy_i(busy_i),
        .dbg_suspend_i(dbg_suspend_i), .idle_ack_o(idle_ack_o),
        .idle_state_o(idle_state_o), .freeze_o(freeze_o), .mod_rst_o(mod_rst_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: next state from the sampled inputs
    always @(posedge clk) begin
        int n_pol, n_imm, n_cnt, n_ack, good;
        if (!rst_n) begin
            m_pol = 2; m_imm = 0; m_cnt = 0; m_ack = 0; m_frz = 0;
            m_rsp = 0; m_err = 0; m_rdata = 0;
        end else begin
            n_pol = m_pol; n_imm = m_imm; n_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
            if (!idle_req_i)    n_ack = 0;
            else if (m_pol == 0) n_ack = 1;
            else if (m_pol == 1) n_ack = 0;
            else                 n_ack = (m_ack == 1 || !busy_i) ? 1 : 0;
            good = (bus_req_i && bus_addr_i == OFF && m_ack == 0) ? 1 : 0;
            m_rsp = bus_req_i;
            m_err = (bus_req_i && !good) ? 1 : 0;
            m_rdata = 0;
            if (good && !bus_we_i)
                m_rdata = (m_pol << 2) | (m_imm << 1) | ((m_cnt > 0) ? 1 : 0);
            if (good && bus_we_i) begin
                n_pol = bus_wdata_i[3:2];
                n_imm = bus_wdata_i[1];
                if (bus_wdata_i[0] && m_cnt == 0) n_cnt = NRST;
            end
            m_frz = (dbg_suspend_i && m_imm == 0) ? 1 : 0;
            m_pol = n_pol; m_imm = n_imm; m_cnt = n_cnt; m_ack = n_ack;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (live && rst_n && !done) begin
            case (m_pol)
                0: check("R2 ack", idle_ack_o, m_ack);
                1: check("R3 ack", idle_ack_o, m_ack);
                2: check("R4 ack", idle_ack_o, m_ack);
                default: check("R5 ack", idle_ack_o, m_ack);
            endcase
            check("R6 idle_state", idle_state_o, m_ack);
            check("R9 freeze", freeze_o, m_frz);
            check("R10 mod_rst", mod_rst_o, (m_cnt > 0) ? 1 : 0);
            check("R12 rsp", bus_rsp_o, m_rsp);
            check("R11 err", bus_err_o, m_err);
            check("R8 rdata", bus_rdata_o, m_rdata);
        end
    end

    task automatic bus_op(input logic we, input logic [7:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output logic er);
        @(negedge clk);
        bus_req_i = 1'b1; bus_we_i = we; bus_addr_i = addr; bus_wdata_i = wd;
        @(negedge clk);
        rd = bus_rdata_o; er = bus_err_o;
        bus_req_i = 1'b0; bus_we_i = 1'b0;
    endtask

    task automatic idle_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic er;
        int pulse;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        live = 1;
        // R1 reset state
        check("R1 ack", idle_ack_o, 0);
        check("R1 mod_rst", mod_rst_o, 0);
        check("R1 freeze", freeze_o, 0);
        bus_op(0, OFF, 0, rd, er);
        check("R1 cfg", rd, 32'h8);
        check("R1 err", er, 0);

        // R4 activity-gated: busy holds off, then hold while busy returns
        busy_i = 1; idle_req_i = 1;
        idle_cycles(5);
        check("R4 wait busy", idle_ack_o, 0);
        busy_i = 0; idle_cycles(1);
        busy_i = 1; idle_cycles(1);
        check("R4 ack", idle_ack_o, 1);
        idle_cycles(3);
        check("R4 hold", idle_ack_o, 1);
        // R7 access while idle
        bus_op(1, OFF, 32'h0, rd, er);
        check("R7 err", er, 1);
        check("R7 rdata", rd, 0);
        idle_req_i = 0; idle_cycles(1);
        check("R6 drop", idle_ack_o, 0);
        bus_op(0, OFF, 0, rd, er);
        check("R7 unchanged", rd, 32'h8);

        // R2 forced
        bus_op(1, OFF, 32'h0, rd, er);
        busy_i = 1; idle_req_i = 1; idle_cycles(1);
        check("R2 ack", idle_ack_o, 1);
        idle_req_i = 0; idle_cycles(2);

        // R3 never
        bus_op(1, OFF, 32'h4, rd, er);
        busy_i = 0; idle_req_i = 1; idle_cycles(10);
        check("R3 ack", idle_ack_o, 0);
        bus_op(0, OFF, 0, rd, er);
        check("R3 access", rd, 32'h4);
        idle_req_i = 0;

        // R5 spare code
        bus_op(1, OFF, 32'hC, rd, er);
        busy_i = 1; idle_req_i = 1; idle_cycles(4);
        check("R5 wait", idle_ack_o, 0);
        busy_i = 0; idle_cycles(1);
        check("R5 ack", idle_ack_o, 1);
        idle_req_i = 0; idle_cycles(2);

        // R8 upper bits ignored, R9 immunity
        bus_op(1, OFF, 32'hFFFF_FFF2, rd, er);
        bus_op(0, OFF, 0, rd, er);
        check("R8 cfg", rd, 32'h2);
        dbg_suspend_i = 1; idle_cycles(2);
        check("R9 immune", freeze_o, 0);
        bus_op(1, OFF, 32'h8, rd, er);
        idle_cycles(1);
        check("R9 freeze", freeze_o, 1);
        dbg_suspend_i = 0; idle_cycles(1);

        // R10 soft reset pulse
        bus_op(1, OFF, 32'h9, rd, er);
        pulse = 0;
        for (int i = 0; i < 8; i++) begin
            if (mod_rst_o) pulse++;
            @(negedge clk);
        end
        check("R10 length", pulse, NRST);
        bus_op(1, OFF, 32'h9, rd, er);
        bus_op(0, OFF, 0, rd, er);
        check("R10 busy bit", rd, 32'h9);
        idle_cycles(6);
        bus_op(0, OFF, 0, rd, er);
        check("R10 cleared", rd, 32'h8);

        // R11 other offsets
        bus_op(0, 8'h0, 0, rd, er);
        check("R11 err", er, 1);
        bus_op(1, 8'h8, 32'h0, rd, er);
        bus_op(0, OFF, 0, rd, er);
        check("R11 unchanged", rd, 32'h8);

        // Random phase, model compared every clock
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            idle_req_i    = ($urandom_range(0, 3) != 0) ? idle_req_i : ~idle_req_i;
            busy_i        = $urandom_range(0, 1);
            dbg_suspend_i = $urandom_range(0, 1);
            bus_req_i     = ($urandom_range(0, 2) == 0);
            bus_we_i      = $urandom_range(0, 1);
            bus_addr_i    = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 15)) : 8'(OFF);
            bus_wdata_i   = $urandom;
        end
        @(negedge clk);
        bus_req_i = 0;
        idle_cycles(8);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule